// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

This block is a pulse accumulator. It has a counter that is 16 bits wide by default, and a two-bit status flag register on a small byte-wide register bus. In event mode the counter advances once for each active edge seen on a single input pin. In gated mode the same pin acts as a gate: while it sits at its active level, the counter advances once for every cycle in which the external prescaled tick input is high. A single control bit picks the polarity. It selects the counted edge in event mode and the active gate level in gated mode.

Two conditions raise flags. One is a wrap of the counter from all ones to zero. The other is an input event: the active edge in event mode, or the trailing edge of the gate in gated mode. Software clears the flags by writing ones to them, but a clear only takes effect while the timer enable or the accumulator enable is high. A fast-clear option also wipes both flags on any access to the count bytes. A level interrupt output combines each flag with its own enable. A parameter can declare the channel absent. The flag register then reads zero and ignores writes.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is zero, both flags are zero and `irq` is low.
- R2: In event mode (`gated_mode`=0) with `acc_en`=1, each synchronized rising edge of `pin_in` adds one to the count when `edge_pol`=1, and each falling edge does when `edge_pol`=0. Edges of the other direction do not count.
- R3: In gated mode (`gated_mode`=1) with `acc_en`=1, the count adds one for each cycle with `tick`=1 while the synchronized pin equals `edge_pol`. Ticks while the gate is inactive do not count.
- R4: With `acc_en`=0 the count holds and no input-edge flag is set.
- R5: The overflow flag (flag register bit 1) sets when the count wraps from its all-ones value to zero.
- R6: The edge flag (flag register bit 0) sets on the active edge in event mode. In gated mode it sets on the gate's trailing edge only, not on its leading edge.
- R7: A write to address 0 clears each flag whose data bit is 1. The clear takes effect only while `tmr_en` or `acc_en` is 1; otherwise the write has no effect.
- R8: With `fast_clr`=1, any read or write of address 1 or 2 clears both flags, subject to the same enable condition as R7. With `fast_clr`=0 such accesses leave the flags unchanged.
- R9: When a flag-set event and a clear of that flag happen in the same cycle, the flag ends set.
- R10: Reads of address 0 return the overflow flag in bit 1, the edge flag in bit 0, and zero in bits 7..2. Address 3 reads zero.
- R11: `irq` is high exactly when (bit 1 flag AND `irq_en[1]`) OR (bit 0 flag AND `irq_en[0]`).
- R12: Address 1 reads and writes the count high byte, and address 2 reads and writes the low byte. A byte write in the same cycle as an increment wins, and that increment is dropped.
- R13: With parameter `CH_PRESENT`=0, address 0 reads zero, flag writes have no effect and `irq` stays low.

Ports follow in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous pulse or gate pin |
| tick | input | 1 | Prescaled clock pulse used in gated mode |
| tmr_en | input | 1 | Timer enable; permits flag clears |
| acc_en | input | 1 | Accumulator enable; permits counting and flag clears |
| gated_mode | input | 1 | 0: event counting, 1: gated tick counting |
| edge_pol | input | 1 | 1: rising edge / high gate, 0: falling edge / low gate |
| fast_clr | input | 1 | Clear both flags on count-byte access |
| irq_en | input | 2 | Interrupt enables, bit 1 overflow, bit 0 edge |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Flag interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first is the counter wrap with a write-one-to-clear of the overflow flag. The bench preloads the count with all ones, holds the gate active, and raises `tick` in the same cycle as the bus write of 0x02 to address 0. The flag must read back set and the count zero. The second pair is an increment with a byte load. The bench pairs a tick with a low-byte write and expects exactly the written value, not that value plus one.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   localparam int unsigned BUS_W = 8;

   typedef enum logic [1:0] {
      ADDR_FLAG = 2'd0,
      ADDR_CNTH = 2'd1,
      ADDR_CNTL = 2'd2,
      ADDR_RSVD = 2'd3
   } pacc_addr_e;

   typedef struct packed {
      logic ovf;
      logic edg;
   } pacc_flags_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic pol,
   output logic gate_act,
   output logic lead_edge,
   output logic trail_edge
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   level_q;
   logic                   level_prev;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= pin_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign level_q = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_prev <= 1'b0;
      else        level_prev <= level_q;
   end

   logic rise;
   logic fall;
   assign rise       = level_q & ~level_prev;
   assign fall       = ~level_q & level_prev;
   assign gate_act   = (level_q == pol);
   assign lead_edge  = pol ? rise : fall;
   assign trail_edge = pol ? fall : rise;

   assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_edge && trail_edge));
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             gated,
   input  logic             ev_edge,
   input  logic             gate_act,
   input  logic             tick,
   input  logic             ld_hi,
   input  logic             ld_lo,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   initial begin
      if (CNT_W < 9 || CNT_W > 16) $error("CNT_W must lie in 9..16");
   end

   logic        inc;
   logic        load;
   logic [15:0] cnt_ext;
   logic [15:0] load_val;

   assign inc     = acc_en & (gated ? (gate_act & tick) : ev_edge);
   assign load    = ld_hi | ld_lo;
   assign cnt_ext = 16'(cnt);

   always_comb begin
      load_val = cnt_ext;
      if (ld_hi) load_val[15:8] = wdata;
      if (ld_lo) load_val[7:0]  = wdata;
   end

   assign wrap = inc & ~load & (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (load) cnt <= load_val[CNT_W-1:0];
      else if (inc)  cnt <= cnt + CNT_ONE;
   end

   assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !load) |=> $stable(cnt));
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !load) |=> ($stable(cnt) || cnt == $past(cnt) + CNT_ONE));
   assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
   import pacc_pkg::*;
#(
   parameter bit CH_PRESENT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        edge_evt,
   input  logic        ovf_evt,
   input  logic        clr_en,
   input  logic        w1c_stb,
   input  logic [1:0]  w1c_mask,
   input  logic        fast_hit,
   output pacc_flags_t flags
);
   generate
      if (CH_PRESENT) begin : g_present
         logic clr_edg;
         logic clr_ovf;
         assign clr_edg = clr_en & ((w1c_stb & w1c_mask[0]) | fast_hit);
         assign clr_ovf = clr_en & ((w1c_stb & w1c_mask[1]) | fast_hit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags <= '0;
            end else begin
               if (edge_evt)     flags.edg <= 1'b1;
               else if (clr_edg) flags.edg <= 1'b0;
               if (ovf_evt)      flags.ovf <= 1'b1;
               else if (clr_ovf) flags.ovf <= 1'b0;
            end
         end

         assert_ovf_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_evt |=> flags.ovf);
         assert_edge_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            edge_evt |=> flags.edg);
         assert_clear_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_en && flags.edg) |=> flags.edg);
         assert_clear_gated_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_en && flags.ovf) |=> flags.ovf);
      end else begin : g_absent
         logic unused_absent;
         assign unused_absent = ^{edge_evt, ovf_evt, clr_en, w1c_stb, w1c_mask, fast_hit};
         assign flags = '0;
      end
   endgenerate
endmodule

// File: rtl/pacc_top.sv
module pacc_top
   import pacc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CH_PRESENT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_in,
   input  logic       tick,
   input  logic       tmr_en,
   input  logic       acc_en,
   input  logic       gated_mode,
   input  logic       edge_pol,
   input  logic       fast_clr,
   input  logic [1:0] irq_en,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   logic             gate_act;
   logic             lead_edge;
   logic             trail_edge;
   logic [CNT_W-1:0] cnt;
   logic [15:0]      cnt_ext;
   logic             wrap;
   pacc_flags_t      flags;

   logic acc_hit;
   logic wr_flag;
   logic ld_hi;
   logic ld_lo;
   logic edge_evt;

   assign acc_hit  = bus_sel & (bus_wr | bus_rd);
   assign wr_flag  = bus_sel & bus_wr & (bus_addr == ADDR_FLAG);
   assign ld_hi    = bus_sel & bus_wr & (bus_addr == ADDR_CNTH);
   assign ld_lo    = bus_sel & bus_wr & (bus_addr == ADDR_CNTL);
   assign edge_evt = acc_en & (gated_mode ? trail_edge : lead_edge);

   pacc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_in),
      .pol       (edge_pol),
      .gate_act  (gate_act),
      .lead_edge (lead_edge),
      .trail_edge(trail_edge)
   );

   pacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (acc_en),
      .gated   (gated_mode),
      .ev_edge (lead_edge),
      .gate_act(gate_act),
      .tick    (tick),
      .ld_hi   (ld_hi),
      .ld_lo   (ld_lo),
      .wdata   (bus_wdata),
      .cnt     (cnt),
      .wrap    (wrap)
   );

   pacc_flags #(.CH_PRESENT(CH_PRESENT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_evt(edge_evt),
      .ovf_evt (wrap),
      .clr_en  (tmr_en | acc_en),
      .w1c_stb (wr_flag),
      .w1c_mask(bus_wdata[1:0]),
      .fast_hit(fast_clr & acc_hit & ((bus_addr == ADDR_CNTH) | (bus_addr == ADDR_CNTL))),
      .flags   (flags)
   );

   assign cnt_ext = 16'(cnt);

   always_comb begin
      unique case (pacc_addr_e'(bus_addr))
         ADDR_FLAG: bus_rdata = {6'b0, flags.ovf, flags.edg};
         ADDR_CNTH: bus_rdata = cnt_ext[15:8];
         ADDR_CNTL: bus_rdata = cnt_ext[7:0];
         default:   bus_rdata = 8'h00;
      endcase
   end

   assign irq = (flags.ovf & irq_en[1]) | (flags.edg & irq_en[0]);

   assert_flag_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_FLAG) |-> (bus_rdata[7:2] == 6'b0));
   assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == 2'b00) |-> !irq);
endmodule

// File: tb/pacc_top_tb.sv
module pacc_top_tb;
   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b0;
   logic       tick = 1'b0;
   logic       tmr_en = 1'b1;
   logic       acc_en = 1'b1;
   logic       gated_mode = 1'b0;
   logic       edge_pol = 1'b1;
   logic       fast_clr = 1'b0;
   logic [1:0] irq_en = 2'b00;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] abs_rdata;
   logic       irq;
   logic       abs_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pacc_top u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick), .tmr_en(tmr_en),
      .acc_en(acc_en), .gated_mode(gated_mode), .edge_pol(edge_pol),
      .fast_clr(fast_clr), .irq_en(irq_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   pacc_top #(.CH_PRESENT(1'b0)) u_absent (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick), .tmr_en(tmr_en),
      .acc_en(acc_en), .gated_mode(gated_mode), .edge_pol(edge_pol),
      .fast_clr(fast_clr), .irq_en(irq_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(abs_rdata), .irq(abs_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic peek_flags(output logic [7:0] d);
      bus_addr = 2'd0;
      #1 d = bus_rdata;
   endtask

   task automatic rd_cnt(output int v);
      logic [7:0] h, l;
      rd(2'd1, h);
      rd(2'd2, l);
      v = {h, l};
   endtask

   task automatic set_cnt(input int v);
      wr(2'd1, v[15:8]);
      wr(2'd2, v[7:0]);
   endtask

   task automatic pin_to(input logic v);
      pin_in = v;
      cyc(4);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] f;
      int v;
      cyc(3);
      // R1 reset state
      peek_flags(f);
      check("R1 flags", f, 0);
      check("R1 irq", irq, 0);
      rst_n = 1'b1;
      cyc(1);
      rd_cnt(v);
      check("R1 count", v, 0);

      // R2 event mode sweep, both polarities
      for (int p = 0; p < 2; p++) begin
         for (int n = 1; n <= 5; n++) begin
            gated_mode = 1'b0;
            edge_pol = p[0];
            pin_to(~p[0]);
            set_cnt(0);
            for (int k = 0; k < n; k++) begin
               pin_to(p[0]);
               pin_to(~p[0]);
            end
            rd_cnt(v);
            check("R2 event count", v, n);
         end
      end

      // R6 event-mode edge flag, R11 irq
      wr(2'd0, 8'h03);
      edge_pol = 1'b1;
      pin_to(1'b0);
      wr(2'd0, 8'h03);
      pin_to(1'b1);
      peek_flags(f);
      check("R6 event edge flag", f, 8'h01);
      irq_en = 2'b10;
      #1 check("R11 irq masked", irq, 0);
      irq_en = 2'b01;
      #1 check("R11 irq edge", irq, 1);
      irq_en = 2'b00;
      // R13 absent channel
      peek_flags(f);
      check("R13 absent flag reg", abs_rdata, 0);
      check("R13 absent irq", abs_irq, 0);
      pin_to(1'b0);

      // R3 gated sweep, both polarities
      for (int p = 0; p < 2; p++) begin
         for (int n = 0; n <= 6; n++) begin
            gated_mode = 1'b1;
            edge_pol = p[0];
            pin_to(~p[0]);
            set_cnt(16'h0100);
            repeat (3) begin tick = 1'b1; cyc(1); tick = 1'b0; cyc(1); end
            pin_to(p[0]);
            for (int k = 0; k < n; k++) begin
               tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
            end
            pin_to(~p[0]);
            rd_cnt(v);
            check("R3 gated count", v, 16'h0100 + n);
         end
      end

      // R6 gated: leading edge no flag, trailing edge sets
      edge_pol = 1'b1;
      pin_to(1'b0);
      wr(2'd0, 8'h03);
      pin_to(1'b1);
      peek_flags(f);
      check("R6 gated leading edge", f, 0);
      pin_to(1'b0);
      peek_flags(f);
      check("R6 gated trailing edge", f, 8'h01);
      wr(2'd0, 8'h01);

      // R4 disabled: hold count, no edge flag
      acc_en = 1'b0;
      set_cnt(16'h0042);
      pin_to(1'b1);
      repeat (4) begin tick = 1'b1; cyc(1); tick = 1'b0; cyc(1); end
      pin_to(1'b0);
      rd_cnt(v);
      check("R4 count held", v, 16'h0042);
      peek_flags(f);
      check("R4 no edge flag", f, 0);
      acc_en = 1'b1;

      // R5 overflow, R9 collision with W1C
      set_cnt(16'hFFFF);
      pin_to(1'b1);
      tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
      cyc(1);
      tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      peek_flags(f);
      check("R9 set wins over clear", f, 8'h02);
      rd_cnt(v);
      check("R5 wrap to zero", v, 0);

      // R12 byte load wins over increment
      tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h10;
      cyc(1);
      tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd_cnt(v);
      check("R12 load beats increment", v, 16'h0010);
      wr(2'd1, 8'hA5);
      rd_cnt(v);
      check("R12 high byte", v, 16'hA510);
      pin_to(1'b0);
      peek_flags(f);
      check("R10 flag layout", f, 8'h03);
      rd(2'd3, f);
      check("R10 reserved addr", f, 0);

      // R7 clear needs an enable
      tmr_en = 1'b0; acc_en = 1'b0;
      wr(2'd0, 8'hFF);
      peek_flags(f);
      check("R7 clear blocked", f, 8'h03);
      tmr_en = 1'b1;
      wr(2'd0, 8'h01);
      peek_flags(f);
      check("R7 clear edge only", f, 8'h02);

      // R8 fast clear
      fast_clr = 1'b0;
      rd(2'd2, f);
      peek_flags(f);
      check("R8 no fast clear when off", f, 8'h02);
      fast_clr = 1'b1;
      tmr_en = 1'b0;
      rd(2'd1, f);
      peek_flags(f);
      check("R8 fast clear needs enable", f, 8'h02);
      tmr_en = 1'b1;
      rd(2'd1, f);
      peek_flags(f);
      check("R8 fast clear on read", f, 0);
      acc_en = 1'b1;
      set_cnt(16'hFFFF);
      pin_to(1'b1);
      tick = 1'b1; cyc(1); tick = 1'b0;
      pin_to(1'b0);
      peek_flags(f);
      check("R8 flags before write", f, 8'h03);
      wr(2'd2, 8'h00);
      peek_flags(f);
      check("R8 fast clear on write", f, 0);
      fast_clr = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule